// File: doc/BRIEF.md
# Program Counter Sequencer with Interrupt Vectors and Return Stack

This block keeps the program counter of a small core whose program space runs from 000H to BFFH, so the counter is 12 bits wide. Each cycle the decoder may pulse one of five strobes: step, jump, call, return or return-from-interrupt. The block turns that strobe into the next counter value. Calls and interrupts save a return address in a hidden six-level stack, and returns restore it. Software cannot reach the stack.

There are two interrupt sources. The first is an external pin whose active edge is chosen by a configuration input. The second is a one-cycle timer overflow pulse. Each source latches a pending request. A request is taken when its own enable is set, the global interrupt enable is set and the stack has a free level. When a request is taken, the current counter is saved, the fixed vector is loaded, the global enable is cleared and a one-cycle acknowledge is raised. A call made while the stack is full replaces the top level and raises a sticky overflow flag.

Top module: `pc_vector_unit`

## Requirements
- R1: When reset is released, the outputs read as follows: `pc_o` is 000H, the stack is empty, `gie_o` is 1, `stk_ovf_o` is 0 and `int_ack_o` is 0.
- R2: After the clock edge that samples `step_i`, `pc_o` is the old PC plus one. After the edge that samples `jump_i`, `pc_o` is `target_i`.
- R3: A sampled `call_i` loads `target_i` into the PC and pushes the old PC plus one. A sampled `ret_i` loads the most recent pushed value.
- R4: The stack holds six levels and returns them in last-in first-out order. A return with an empty stack loads 000H and leaves the stack empty.
- R5: `ext_fall_sel_i`=0 selects rising edges of `ext_pin_i` and 1 selects falling edges. The opposite edge sets no request. An accepted external request loads 004H two edges after the pin changes.
- R6: A sampled `tmr_ovf_i` pulse sets a timer request. The timer request, once accepted, loads 008H.
- R7: A request is accepted only when it is pending, its own enable is 1, `gie_o` is 1 and the stack is not full. The request stays pending until it is accepted.
- R8: In the cycle an interrupt is accepted, the saved value is the current PC, meaning the instruction not yet executed. Any strobe in that cycle is ignored.
- R9: When both requests are pending, the external one is served first. The timer request is served after it.
- R10: Acceptance clears `gie_o`. Return-from-interrupt pops the stack into the PC and sets `gie_o` to 1.
- R11: A call with six levels in use overwrites the sixth level and sets `stk_ovf_o`. That flag stays 1 until reset.
- R12: `int_ack_o` is 1 for exactly the cycle in which the vector first shows on `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Advance PC by one |
| jump_i | input | 1 | Load PC from target |
| call_i | input | 1 | Push return address, load target |
| ret_i | input | 1 | Pop PC |
| reti_i | input | 1 | Pop PC and set global enable |
| target_i | input | 12 | Jump or call destination |
| ext_pin_i | input | 1 | External interrupt pin |
| ext_fall_sel_i | input | 1 | 0 rising, 1 falling edge |
| ext_en_i | input | 1 | External source enable |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| tmr_en_i | input | 1 | Timer source enable |
| pc_o | output | 12 | Current program counter |
| int_ack_o | output | 1 | Interrupt acknowledge pulse |
| gie_o | output | 1 | Global interrupt enable |
| stk_ovf_o | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the block with its default parameters: a 12-bit PC, a stack depth of six and vectors at 000H, 004H and 008H. With a depth of six, a short run of calls can fill the stack. That brings within reach the blocked request while the stack is full, the overwrite and overflow flag on a seventh call, and the held request that is taken as soon as a return frees a level. The run also unwinds the stack completely, which brings the empty-stack return case within reach.

// File: rtl/pcseq_pkg.sv
// Package: shared selector type for the PC sequencer.
// Assumes: consumers use the enum only for the next-PC source choice.
package pcseq_pkg;
    typedef enum logic [2:0] {
        NXT_HOLD,
        NXT_INC,
        NXT_JUMP,
        NXT_CALL,
        NXT_POP,
        NXT_VEC
    } nxt_src_e;
endpackage

// File: rtl/pcseq_req.sv
// Interrupt request latch: detects the selected edge on the external pin and
// latches the timer pulse; each request holds until its clear input.
// Assumes: the pin is already synchronous to clk.
module pcseq_req (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin_i,
    input  logic fall_sel_i,
    input  logic tmr_ovf_i,
    input  logic clr_ext_i,
    input  logic clr_tmr_i,
    output logic ext_pend_o,
    output logic tmr_pend_o
);
    logic pin_q;
    logic edge_hit;

    // Edge of the chosen polarity between last sample and now.
    always_comb edge_hit = fall_sel_i ? (pin_q & ~ext_pin_i) : (~pin_q & ext_pin_i);

    // Pin history and pending flags; new events win over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q      <= 1'b0;
            ext_pend_o <= 1'b0;
            tmr_pend_o <= 1'b0;
        end else begin
            pin_q      <= ext_pin_i;
            ext_pend_o <= (ext_pend_o & ~clr_ext_i) | edge_hit;
            tmr_pend_o <= (tmr_pend_o & ~clr_tmr_i) | tmr_ovf_i;
        end
    end

    p_edge_pol_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_pend_o) |-> ($past(ext_pin_i) != $past(fall_sel_i)));
    p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_pend_o && !clr_tmr_i) |=> tmr_pend_o);
endmodule

// File: rtl/pcseq_stack.sv
// Return-address stack: DEPTH levels of W bits, invisible to software.
// Push on full overwrites the top level and sets a sticky overflow flag.
// Pop on empty yields zero. Assumes push and pop never coincide.
module pcseq_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o,
    output logic         full_o,
    output logic         ovf_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  lvl_q [DEPTH];
    logic [CW-1:0] wr_idx;
    logic          empty;

    // Derived occupancy and write slot.
    always_comb begin
        full_o = (cnt_q == CW'(DEPTH));
        empty  = (cnt_q == '0);
        wr_idx = full_o ? CW'(DEPTH - 1) : cnt_q;
        top_o  = empty ? '0 : lvl_q[cnt_q - 1'b1];
    end

    // Per-level storage written only by a push aimed at it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[g] <= '0;
            else if (push_i && wr_idx == CW'(g))
                lvl_q[g] <= push_data_i;
        end
    end

    // Occupancy count and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_o <= 1'b0;
        end else if (push_i) begin
            if (full_o) ovf_o <= 1'b1;
            else        cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    p_ovf_from_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(full_o && push_i));
    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
endmodule

// File: rtl/pc_vector_unit.sv
// PC sequencer top: chooses the next PC from strobes, return stack and
// interrupt vectors; arbitrates external over timer requests.
// Assumes at most one strobe per cycle; accepted interrupts pre-empt strobes.
module pc_vector_unit #(
    parameter int          PC_W    = 12,
    parameter int          DEPTH   = 6,
    parameter logic [11:0] RST_VEC = 12'h000,
    parameter logic [11:0] EXT_VEC = 12'h004,
    parameter logic [11:0] TMR_VEC = 12'h008
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            jump_i,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            reti_i,
    input  logic [PC_W-1:0] target_i,
    input  logic            ext_pin_i,
    input  logic            ext_fall_sel_i,
    input  logic            ext_en_i,
    input  logic            tmr_ovf_i,
    input  logic            tmr_en_i,
    output logic [PC_W-1:0] pc_o,
    output logic            int_ack_o,
    output logic            gie_o,
    output logic            stk_ovf_o
);
    import pcseq_pkg::*;

    logic            ext_pend, tmr_pend;
    logic            take_ext, take_tmr, take;
    logic            stk_full, stk_push, stk_pop;
    logic [PC_W-1:0] stk_top, push_val, pc_inc;
    nxt_src_e        nxt;

    pcseq_req u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin_i  (ext_pin_i),
        .fall_sel_i (ext_fall_sel_i),
        .tmr_ovf_i  (tmr_ovf_i),
        .clr_ext_i  (take_ext),
        .clr_tmr_i  (take_tmr),
        .ext_pend_o (ext_pend),
        .tmr_pend_o (tmr_pend)
    );

    pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_data_i (push_val),
        .top_o       (stk_top),
        .full_o      (stk_full),
        .ovf_o       (stk_ovf_o)
    );

    // Interrupt acceptance with fixed external-first order.
    always_comb begin
        take_ext = ext_pend & ext_en_i & gie_o & ~stk_full;
        take_tmr = tmr_pend & tmr_en_i & gie_o & ~stk_full & ~take_ext;
        take     = take_ext | take_tmr;
    end

    // Next-PC source selection and stack control.
    always_comb begin
        pc_inc = pc_o + 1'b1;
        if (take)                 nxt = NXT_VEC;
        else if (call_i)          nxt = NXT_CALL;
        else if (ret_i || reti_i) nxt = NXT_POP;
        else if (jump_i)          nxt = NXT_JUMP;
        else if (step_i)          nxt = NXT_INC;
        else                      nxt = NXT_HOLD;
        stk_push = (nxt == NXT_VEC) || (nxt == NXT_CALL);
        stk_pop  = (nxt == NXT_POP);
        push_val = (nxt == NXT_VEC) ? pc_o : pc_inc;
    end

    // PC, acknowledge and global enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o      <= RST_VEC[PC_W-1:0];
            int_ack_o <= 1'b0;
            gie_o     <= 1'b1;
        end else begin
            int_ack_o <= take;
            case (nxt)
                NXT_VEC:  pc_o <= take_ext ? EXT_VEC[PC_W-1:0] : TMR_VEC[PC_W-1:0];
                NXT_CALL: pc_o <= target_i;
                NXT_POP:  pc_o <= stk_top;
                NXT_JUMP: pc_o <= target_i;
                NXT_INC:  pc_o <= pc_inc;
                default:  pc_o <= pc_o;
            endcase
            if (take)
                gie_o <= 1'b0;
            else if (nxt == NXT_POP && reti_i)
                gie_o <= 1'b1;
        end
    end

    p_ack_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack_o |-> (pc_o == EXT_VEC[PC_W-1:0] || pc_o == TMR_VEC[PC_W-1:0]));
    p_ack_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack_o |-> $past(!stk_full && gie_o));
    p_ack_gie_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack_o |-> !gie_o);
    p_ext_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack_o && $past(ext_pend && ext_en_i)) |-> pc_o == EXT_VEC[PC_W-1:0]);
endmodule

// File: tb/tb_pc_vector_unit.sv
module tb_pc_vector_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 0, jump_i = 0, call_i = 0, ret_i = 0, reti_i = 0;
    logic [11:0] target_i = '0;
    logic        ext_pin_i = 0, ext_fall_sel_i = 0, ext_en_i = 1;
    logic        tmr_ovf_i = 0, tmr_en_i = 1;
    logic [11:0] pc_o;
    logic        int_ack_o, gie_o, stk_ovf_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
        .call_i(call_i), .ret_i(ret_i), .reti_i(reti_i), .target_i(target_i),
        .ext_pin_i(ext_pin_i), .ext_fall_sel_i(ext_fall_sel_i), .ext_en_i(ext_en_i),
        .tmr_ovf_i(tmr_ovf_i), .tmr_en_i(tmr_en_i), .pc_o(pc_o),
        .int_ack_o(int_ack_o), .gie_o(gie_o), .stk_ovf_o(stk_ovf_o)
    );

    typedef struct packed {
        logic [11:0] pc;
        logic        ack;
        logic        gie;
        logic        ovf;
    } exp_t;

    exp_t        exp_q[$];
    string       tag_q[$];
    int          checks = 0, failures = 0;
    bit          done = 0;

    logic [11:0] pc_m = 12'h000;
    bit          gie_m = 1, ovf_m = 0;
    logic [11:0] stk_m[$];

    // Monitor: compare outputs just after each edge against the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pc_o !== e.pc || int_ack_o !== e.ack || gie_o !== e.gie || stk_ovf_o !== e.ovf) begin
                    failures++;
                    $display("FAIL %s: pc=%h ack=%b gie=%b ovf=%b expected pc=%h ack=%b gie=%b ovf=%b",
                             t, pc_o, int_ack_o, gie_o, stk_ovf_o, e.pc, e.ack, e.gie, e.ovf);
                end
            end
        end
    end

    function automatic void m_push(input logic [11:0] v);
        if (stk_m.size() < 6) stk_m.push_back(v);
        else begin stk_m[5] = v; ovf_m = 1; end
    endfunction

    function automatic logic [11:0] m_pop();
        if (stk_m.size() == 0) return 12'h000;
        return stk_m.pop_back();
    endfunction

    // Driver: one cycle of strobes; intk 0 none, 1 external, 2 timer accepted.
    task automatic cyc(input bit st, input bit jp, input bit cl, input bit rt,
                       input bit ri, input logic [11:0] tgt, input int intk, input string tag);
        exp_t e;
        step_i = st; jump_i = jp; call_i = cl; ret_i = rt; reti_i = ri; target_i = tgt;
        @(posedge clk);
        e.ack = (intk != 0);
        if (intk != 0) begin
            m_push(pc_m);
            pc_m = (intk == 1) ? 12'h004 : 12'h008;
            gie_m = 0;
        end else if (cl) begin
            m_push(pc_m + 12'h1);
            pc_m = tgt;
        end else if (rt || ri) begin
            pc_m = m_pop();
            if (ri) gie_m = 1;
        end else if (jp) pc_m = tgt;
        else if (st) pc_m = pc_m + 12'h1;
        e.pc = pc_m; e.gie = gie_m; e.ovf = ovf_m;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        step_i = 0; jump_i = 0; call_i = 0; ret_i = 0; reti_i = 0;
    endtask

    task automatic idle(input int intk, input string tag);
        cyc(0, 0, 0, 0, 0, 12'h0, intk, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        idle(0, "R1 reset state");

        // R2 steps and jump
        cyc(1, 0, 0, 0, 0, 0, 0, "R2 step");
        cyc(1, 0, 0, 0, 0, 0, 0, "R2 step");
        cyc(1, 0, 0, 0, 0, 0, 0, "R2 step");
        cyc(0, 1, 0, 0, 0, 12'h020, 0, "R2 jump");
        // R3 call and return
        cyc(0, 0, 1, 0, 0, 12'h100, 0, "R3 call");
        cyc(1, 0, 0, 0, 0, 0, 0, "R2 step in sub");
        cyc(0, 0, 0, 1, 0, 0, 0, "R3 return");

        // R5 rising edge
        ext_pin_i = 1;
        idle(0, "R5 request latch");
        idle(1, "R5 rising vector");
        cyc(0, 0, 0, 0, 1, 0, 0, "R10 reti");
        // R5 falling edge with select=1
        ext_fall_sel_i = 1;
        idle(0, "R5 select change no edge");
        ext_pin_i = 0;
        idle(0, "R5 falling latch");
        idle(1, "R5 falling vector");
        cyc(0, 0, 0, 0, 1, 0, 0, "R10 reti");
        // R5 opposite edge ignored
        ext_pin_i = 1;
        idle(0, "R5 rising ignored");
        idle(0, "R5 rising ignored");
        ext_fall_sel_i = 0;
        ext_pin_i = 0;
        idle(0, "R5 falling ignored");
        idle(0, "R5 falling ignored");

        // R6 timer, R8 strobe ignored during acceptance
        tmr_ovf_i = 1;
        idle(0, "R6 timer latch");
        tmr_ovf_i = 0;
        cyc(1, 0, 0, 0, 0, 0, 2, "R8 timer vector strobe ignored");
        cyc(0, 0, 0, 0, 1, 0, 0, "R8 reti returns unexecuted pc");

        // R9 both at once
        ext_pin_i = 1; tmr_ovf_i = 1;
        idle(0, "R9 both latch");
        tmr_ovf_i = 0;
        idle(1, "R9 external first");
        idle(0, "R10 gie blocks timer");
        cyc(0, 0, 0, 0, 1, 0, 0, "R10 reti sets gie");
        idle(2, "R9 timer second");
        cyc(0, 0, 0, 0, 1, 0, 0, "R10 reti");

        // R7 per-source enable
        tmr_en_i = 0;
        tmr_ovf_i = 1;
        idle(0, "R7 disabled latch");
        tmr_ovf_i = 0;
        idle(0, "R7 disabled no ack");
        cyc(1, 0, 0, 0, 0, 0, 0, "R7 disabled no ack");
        tmr_en_i = 1;
        idle(2, "R7 held request taken");
        cyc(0, 0, 0, 0, 1, 0, 0, "R10 reti");

        // R4 R11 fill stack
        for (int i = 0; i < 6; i++)
            cyc(0, 0, 1, 0, 0, 12'h200 + 12'(i * 16), 0, "R4 fill call");
        ext_pin_i = 0; ext_fall_sel_i = 1;
        idle(0, "R7 full latch");
        idle(0, "R7 full blocks request");
        cyc(0, 0, 1, 0, 0, 12'h300, 0, "R11 overflow call");
        cyc(0, 0, 0, 1, 0, 0, 0, "R11 overwritten level");
        idle(1, "R7 room frees request");
        cyc(0, 0, 0, 0, 1, 0, 0, "R10 reti");
        for (int i = 0; i < 5; i++)
            cyc(0, 0, 0, 1, 0, 0, 0, "R4 unwind lifo");
        cyc(0, 0, 0, 1, 0, 0, 0, "R4 empty return");
        idle(0, "R11 flag sticky");

        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule